// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block gathers the four interrupt conditions of a serial port: a receive line error, received data waiting, an empty transmit holding slot, and a change on the modem control lines. Each condition is masked by a bit in a small enable register, and the surviving ones drive one active-high interrupt line. A byte-wide identification value names the most urgent enabled condition, so a service routine can branch straight to the right handler.

The processor writes the enable register through a simple write strobe and can read it back at any time. Reading the identification value is marked by a read strobe, which may be held for one or more cycles. While that strobe is high the identification value is frozen, so the processor sees one consistent answer. Conditions keep being tracked during the read, and the current answer appears once the strobe drops. The condition inputs are levels: a source is cleared by logic outside this block, which pulls its input low.

Top module: `uirq_ident`

## Requirements
- R1: When several enabled conditions are pending, the identification value names the most urgent one. The order from most to least urgent is line error, received data, transmit empty, then modem change.
- R2: Identification bit 0 is 0 when at least one enabled condition is pending and 1 when none is.
- R3: Identification bits 2:1 hold the source code: 2'b11 for line error, 2'b10 for received data, 2'b01 for transmit empty and 2'b00 for modem change. Bits 7:3 are always 0. The full byte is therefore 8'h06, 8'h04, 8'h02, 8'h00, or 8'h01 when nothing is pending.
- R4: `id_out` is a register. At each rising clock edge where `id_rd` is low, it loads the value computed from the current conditions and enables. At each edge where `id_rd` is high, it keeps its value. A condition that arrives during a read therefore shows from the first edge after `id_rd` falls.
- R5: A clock edge with `cfg_we` high stores `cfg_wdata[3:0]` in the enable register. Enable bit 0 gates received data, bit 1 gates transmit empty, bit 2 gates line error and bit 3 gates modem change. `cfg_rdata` returns the four stored bits, and bits 7:4 always read 0.
- R6: A condition whose enable bit is 0 is never named in the identification value and never raises `irq_out`, whatever its input level.
- R7: `irq_out` is combinational. In the same cycle it equals the OR of every pending condition whose enable bit is 1, and it is not frozen by `id_rd`.
- R8: After reset the enable register is 0, `cfg_rdata` is 8'h00, `id_out` is 8'h01 and `irq_out` is 0.
- R9: With all four enable bits at 0, `irq_out` stays 0 and `id_out` stays 8'h01 for any pattern of conditions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the enable register |
| cfg_wdata | input | DATA_W | Enable register write data |
| cfg_rdata | output | DATA_W | Enable register read-back |
| id_rd | input | 1 | Identification read strobe; the value is frozen while it is high |
| id_out | output | DATA_W | Identification value |
| irq_out | output | 1 | Interrupt request, active high |
| cond_lsr | input | 1 | Receive line error condition |
| cond_rxd | input | 1 | Received data ready condition |
| cond_thre | input | 1 | Transmit holding empty condition |
| cond_msc | input | 1 | Modem status change condition |

## Verification
Directed patterns raise all four conditions and then remove them one at a time from the most urgent down. This separates a correct priority chain from one that is reversed or skips a level. A walk through single conditions under partial masks checks each enable bit against the source it gates, which shows up any swap in the enable mapping. A held read strobe, with a condition raised during the hold, separates a true freeze from a transparent or late release. Random mixes of conditions, enable writes and strobe bursts of varying length then compare every cycle against a bench model.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
   localparam int SRC_N  = 4;
   localparam int CODE_W = $clog2(SRC_N);
   localparam int EN_W   = SRC_N;

   // source index doubles as its identification code; larger index wins
   typedef enum logic [CODE_W-1:0] {
      SRC_MSC  = 2'd0,
      SRC_THRE = 2'd1,
      SRC_RXD  = 2'd2,
      SRC_LSR  = 2'd3
   } src_e;

   // position of each source's gate inside the enable register
   function automatic int en_pos(input int src);
      case (src)
         3:       en_pos = 2;
         2:       en_pos = 0;
         1:       en_pos = 1;
         default: en_pos = 3;
      endcase
   endfunction
endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg
   import uirq_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [EN_W-1:0]   wbits,
   output logic [EN_W-1:0]   en,
   output logic [DATA_W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  en <= '0;
      else if (we) en <= wbits;
   end

   always_comb begin
      rdata           = '0;
      rdata[EN_W-1:0] = en;
   end
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
   import uirq_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic [SRC_N-1:0]  pend,
   output logic              any,
   output logic [DATA_W-1:0] id_live
);
   logic [SRC_N:0]     above;
   logic [SRC_N-1:0]   win;
   logic [CODE_W-1:0]  code;

   assign above[SRC_N] = 1'b0;

   for (genvar i = SRC_N - 1; i >= 0; i--) begin : g_chain
      assign win[i]   = pend[i] & ~above[i+1];
      assign above[i] = above[i+1] | pend[i];
   end

   assign any = above[0];

   always_comb begin
      code = '0;
      for (int i = 0; i < SRC_N; i++) begin
         if (win[i]) code = CODE_W'(i);
      end
   end

   always_comb begin
      id_live           = '0;
      id_live[CODE_W:1] = code;
      id_live[0]        = ~any;
   end
endmodule

// File: rtl/uirq_id_hold.sv
module uirq_id_hold #(
   parameter int DATA_W       = 8,
   parameter bit HOLD_ON_READ = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic [DATA_W-1:0] live,
   output logic [DATA_W-1:0] shown
);
   localparam logic [DATA_W-1:0] ID_IDLE = DATA_W'(1);

   if (HOLD_ON_READ) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   shown <= ID_IDLE;
         else if (!rd) shown <= live;
      end
   end else begin : g_pass
      logic unused_rd;
      assign unused_rd = rd;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) shown <= ID_IDLE;
         else        shown <= live;
      end
   end
endmodule

// File: rtl/uirq_ident.sv
module uirq_ident
   import uirq_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit HOLD_ON_READ = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              id_rd,
   output logic [DATA_W-1:0] id_out,
   output logic              irq_out,
   input  logic              cond_lsr,
   input  logic              cond_rxd,
   input  logic              cond_thre,
   input  logic              cond_msc
);
   if (DATA_W < 8) begin : g_bad_width
      $error("uirq_ident: DATA_W must be at least 8");
   end
   if (SRC_N != 4) begin : g_bad_count
      $error("uirq_ident: exactly four sources are supported");
   end

   logic [EN_W-1:0]   en;
   logic [SRC_N-1:0]  raw;
   logic [SRC_N-1:0]  pend;
   logic [DATA_W-1:0] id_live;
   logic              any_pend;
   logic              unused_whi;

   assign unused_whi = ^cfg_wdata[DATA_W-1:EN_W];

   assign raw[SRC_LSR]  = cond_lsr;
   assign raw[SRC_RXD]  = cond_rxd;
   assign raw[SRC_THRE] = cond_thre;
   assign raw[SRC_MSC]  = cond_msc;

   for (genvar s = 0; s < SRC_N; s++) begin : g_gate
      assign pend[s] = raw[s] & en[en_pos(s)];
   end

   uirq_enable_reg #(.DATA_W(DATA_W)) u_en (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wbits (cfg_wdata[EN_W-1:0]),
      .en    (en),
      .rdata (cfg_rdata)
   );

   uirq_prio_enc #(.DATA_W(DATA_W)) u_enc (
      .pend    (pend),
      .any     (any_pend),
      .id_live (id_live)
   );

   uirq_id_hold #(.DATA_W(DATA_W), .HOLD_ON_READ(HOLD_ON_READ)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (id_rd),
      .live  (id_live),
      .shown (id_out)
   );

   assign irq_out = any_pend;
endmodule

// File: rtl/uirq_ident_chk.sv
module uirq_ident_chk #(
   parameter int DATA_W = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] cfg_rdata,
   input logic              id_rd,
   input logic [DATA_W-1:0] id_out,
   input logic              irq_out,
   input logic              cond_lsr
);
   // R2: no request and no read at an edge -> idle code follows
   a_r2_idle_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_out && !id_rd) |=> (id_out == DATA_W'(1)));

   // R2: a request seen at an unfrozen edge -> pending bit low next
   a_r2_pending_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && !id_rd) |=> !id_out[0]);

   // R1: an enabled line error always wins
   a_r1_line_error_first: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_lsr && cfg_rdata[2] && !id_rd) |=> (id_out == DATA_W'(6)));

   // R3: upper identification bits stay zero
   a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (id_out[DATA_W-1:3] == '0));

   // R4: value frozen across an edge where the strobe was high
   a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(id_rd) |-> (id_out == $past(id_out)));

   // R5: enable read-back upper bits are zero
   a_r5_en_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[DATA_W-1:4] == '0));

   // R9: all gates closed -> no request
   a_r9_all_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[3:0] == 4'b0) |-> !irq_out);
endmodule

bind uirq_ident uirq_ident_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_rdata (cfg_rdata),
   .id_rd     (id_rd),
   .id_out    (id_out),
   .irq_out   (irq_out),
   .cond_lsr  (cond_lsr)
);

// File: tb/tb_uirq_ident.sv
module tb_uirq_ident;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       id_rd = 1'b0;
   logic [7:0] id_out;
   logic       irq_out;
   logic       c_lsr = 1'b0, c_rxd = 1'b0, c_thre = 1'b0, c_msc = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [3:0] exp_en = '0;
   logic [7:0] exp_id = 8'h01;

   always #(CLK_PERIOD/2) clk = ~clk;

   uirq_ident dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .id_rd(id_rd), .id_out(id_out), .irq_out(irq_out),
      .cond_lsr(c_lsr), .cond_rxd(c_rxd), .cond_thre(c_thre), .cond_msc(c_msc)
   );

   // enable bit0 rxd, bit1 thre, bit2 lsr, bit3 msc
   function automatic logic [7:0] id_fn(input logic l, r, t, m, input logic [3:0] e);
      if (l && e[2])      return 8'h06;
      else if (r && e[0]) return 8'h04;
      else if (t && e[1]) return 8'h02;
      else if (m && e[3]) return 8'h00;
      else                return 8'h01;
   endfunction

   function automatic logic irq_fn(input logic l, r, t, m, input logic [3:0] e);
      return (l && e[2]) || (r && e[0]) || (t && e[1]) || (m && e[3]);
   endfunction

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      if (!id_rd) exp_id = id_fn(c_lsr, c_rxd, c_thre, c_msc, exp_en);
      if (cfg_we) exp_en = cfg_wdata[3:0];
      @(negedge clk);
   endtask

   task automatic check_all(input string tag);
      chk(id_out, exp_id, tag);
      chk({7'b0, irq_out}, {7'b0, irq_fn(c_lsr, c_rxd, c_thre, c_msc, exp_en)}, "R7 irq");
      chk(cfg_rdata, {4'b0, exp_en}, "R5 readback");
   endtask

   task automatic write_en(input logic [7:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic set_c(input logic [3:0] v);
      {c_lsr, c_rxd, c_thre, c_msc} = v;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int seed;
      seed = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      // R8 reset state
      chk(id_out, 8'h01, "R8 id after reset");
      chk({7'b0, irq_out}, 8'h00, "R8 irq after reset");
      chk(cfg_rdata, 8'h00, "R8 enable after reset");
      rst_n = 1'b1;
      tick();
      set_c(4'b1111);
      tick();
      chk(id_out, 8'h01, "R9 conditions with enables zero");
      chk({7'b0, irq_out}, 8'h00, "R9 irq with enables zero");

      // R5 upper write bits ignored
      write_en(8'hFF);
      chk(cfg_rdata, 8'h0F, "R5 upper bits dropped");
      tick();
      // R1 peel from the top
      chk(id_out, 8'h06, "R1 all pending -> line error");
      set_c(4'b0111); tick(); chk(id_out, 8'h04, "R1 rxd next");
      set_c(4'b0011); tick(); chk(id_out, 8'h02, "R1 thre next");
      set_c(4'b0001); tick(); chk(id_out, 8'h00, "R1 msc last");
      set_c(4'b0000); tick(); chk(id_out, 8'h01, "R2 none pending");
      chk({7'b0, irq_out}, 8'h00, "R7 no request");

      // R3 each single source, R5/R6 enable mapping
      for (int s = 0; s < 4; s++) begin
         set_c(4'b1000 >> s);
         tick();
         chk(id_out, 8'h06 - 8'(2 * s), "R3 single source code");
         chk({7'b0, irq_out}, 8'h01, "R7 single source request");
      end
      write_en(8'h0B);           // line error gate off
      set_c(4'b1000); tick();
      chk(id_out, 8'h01, "R6 masked line error hidden");
      chk({7'b0, irq_out}, 8'h00, "R6 masked line error no irq");
      set_c(4'b1100); tick();
      chk(id_out, 8'h04, "R6 masked source skipped");
      write_en(8'h0E);           // rxd gate off
      set_c(4'b0100); tick();
      chk(id_out, 8'h01, "R5 bit0 gates rxd");
      write_en(8'h07);           // msc gate off
      set_c(4'b0001); tick();
      chk(id_out, 8'h01, "R5 bit3 gates msc");

      // R4 freeze
      write_en(8'h0F);
      set_c(4'b0000); tick();
      id_rd = 1'b1; tick();
      set_c(4'b1000);
      tick(); chk(id_out, 8'h01, "R4 frozen during read");
      chk({7'b0, irq_out}, 8'h01, "R7 irq live during read");
      tick(); tick(); chk(id_out, 8'h01, "R4 still frozen");
      id_rd = 1'b0;
      chk(id_out, 8'h01, "R4 not yet released");
      tick(); chk(id_out, 8'h06, "R4 shown after release");

      // random mix
      for (int n = 0; n < 4000; n++) begin
         set_c(4'($urandom()));
         cfg_we = ($urandom() % 10) == 0;
         cfg_wdata = 8'($urandom());
         if (($urandom() % 5) == 0) id_rd = ~id_rd;
         tick();
         check_all(id_rd ? "R4 random" : "R1 random");
      end
      cfg_we = 1'b0; id_rd = 1'b0;
      write_en(8'h00);
      set_c(4'b1111); tick();
      check_all("R9 final off");
      finish_run();
   end
endmodule